// File: doc/BRIEF.md
# External Interrupt Edge/Level Detector

This block builds the external interrupt request for a small CPU core. The request can come from a dedicated active-low interrupt pin, and also from a port of general-purpose pins. A port pin takes part in the interrupt logic only while its pullup enable is set. All active sources are merged into one active-low combined source. That source passes through a two-flop synchronizer into the CPU clock domain. A falling edge of the synchronized source sets a request latch.

A static mode input picks the trigger type. In edge-only mode, only the latch drives the request. In edge-and-level mode, the request also stays high for as long as the synchronized combined source is low.

The CPU pulses a clear strobe at the start of its service routine. Because the latch is cleared early, a new falling edge during the routine is captured and held. It is then taken as soon as the CPU unmasks interrupts. The mask bit and vector selection sit outside this block.

Top module: `ext_irq_detect`

## Requirements
- R1: A falling edge of the combined source sets the request latch. If the inputs change just before clock edge k, `req_o` rises after edge k+2: two synchronizer stages, then the latch.
- R2: Once set, the request latch stays set until `clr_i` is sampled high, even after every source has returned high.
- R3: A port pin whose `pull_en_i` bit is 1 acts as an extra source. Its falling edge raises `req_o` while `irq_ni` stays high.
- R4: A port pin whose `pull_en_i` bit is 0 is ignored. Driving it low raises no request.
- R5: In edge-only mode (`level_mode_i` = 0), a source held low after a clear raises no new request.
- R6: In edge-and-level mode (`level_mode_i` = 1), `req_o` is high while any enabled source is synchronized low. It rises one edge sooner than the latch does and stays high through a clear. It drops two edges after the last source is released, once the latch is clear.
- R7: In edge-only mode, a `clr_i` pulse with no new edge drops `req_o` after the next clock edge.
- R8: When a clear and a falling edge reach the latch on the same clock edge, the edge wins and `req_o` stays high.
- R9: The combined source is the AND of all active sources. A falling edge on one source while another active source is already low is not a new edge.
- R10: During and after reset, with all pins high, `req_o` is 0. The synchronizer stages reset to the idle-high level, so leaving reset produces no false edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | CPU clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| irq_ni | input | 1 | Dedicated interrupt pin, active low, asynchronous |
| port_i | input | NUM_PORT | General-purpose port pins, asynchronous |
| pull_en_i | input | NUM_PORT | Per-pin pullup enable; 1 attaches the pin as an interrupt source |
| level_mode_i | input | 1 | Trigger mode: 0 edge-only, 1 edge plus level |
| clr_i | input | 1 | Latch clear strobe from the CPU |
| req_o | output | 1 | Synchronized interrupt request |

## Verification
The clear strobe and a freshly detected falling edge can both reach the latch on the same clock edge. This is the case where a pulse arrives at the very start of service. The bench provokes it directly: it drops the pin and raises `clr_i` exactly two edges later, so both land together. It then expects `req_o` to stay high (R8). The random phase also overlaps the two often, using frequent clear strobes and pin toggles. There, every cycle is judged against a cycle-timed bench model of the synchronizer and latch, built from the R1 and R6 timing.

// File: rtl/ext_irq_pkg.sv
package ext_irq_pkg;
  typedef enum logic {
    TRIG_EDGE       = 1'b0,
    TRIG_EDGE_LEVEL = 1'b1
  } trig_mode_e;
endpackage

// File: rtl/ext_irq_combine.sv
module ext_irq_combine #(
  parameter int NUM_PORT = 8
) (
  input  logic                irq_ni,
  input  logic [NUM_PORT-1:0] port_i,
  input  logic [NUM_PORT-1:0] pull_en_i,
  output logic                src_no
);
  logic [NUM_PORT-1:0] gated_n;

  // A disabled pin reads as idle high.
  for (genvar i = 0; i < NUM_PORT; i++) begin : g_pin
    assign gated_n[i] = port_i[i] | ~pull_en_i[i];
  end

  assign src_no = irq_ni & (&gated_n);
endmodule

// File: rtl/ext_irq_sync.sv
module ext_irq_sync #(
  parameter int   STAGES    = 2,
  parameter logic RESET_VAL = 1'b1
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic d_i,
  output logic q_o
);
  logic [STAGES-1:0] stage_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) stage_q <= {STAGES{RESET_VAL}};
    else         stage_q <= {stage_q[STAGES-2:0], d_i};
  end

  assign q_o = stage_q[STAGES-1];
endmodule

// File: rtl/ext_irq_edge_latch.sv
module ext_irq_edge_latch
  import ext_irq_pkg::*;
(
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       src_ns_i,
  input  logic       clr_i,
  input  trig_mode_e mode_i,
  output logic       fall_o,
  output logic       latch_o,
  output logic       req_o
);
  logic src_prev_q;
  logic latch_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      src_prev_q <= 1'b1;
      latch_q    <= 1'b0;
    end else begin
      src_prev_q <= src_ns_i;
      // set wins over clear: a pulse at service start is kept
      latch_q    <= fall_o | (latch_q & ~clr_i);
    end
  end

  assign fall_o  = src_prev_q & ~src_ns_i;
  assign latch_o = latch_q;
  assign req_o   = latch_q | ((mode_i == TRIG_EDGE_LEVEL) & ~src_ns_i);
endmodule

// File: rtl/ext_irq_detect.sv
module ext_irq_detect
  import ext_irq_pkg::*;
#(
  parameter int NUM_PORT    = 8,
  parameter int SYNC_STAGES = 2
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic                irq_ni,
  input  logic [NUM_PORT-1:0] port_i,
  input  logic [NUM_PORT-1:0] pull_en_i,
  input  logic                level_mode_i,
  input  logic                clr_i,
  output logic                req_o
);
  logic       src_n;
  logic       src_ns;
  logic       fall;
  logic       latch_q;
  trig_mode_e mode;

  assign mode = trig_mode_e'(level_mode_i);

  ext_irq_combine #(.NUM_PORT(NUM_PORT)) u_combine (
    .irq_ni    (irq_ni),
    .port_i    (port_i),
    .pull_en_i (pull_en_i),
    .src_no    (src_n)
  );

  ext_irq_sync #(.STAGES(SYNC_STAGES), .RESET_VAL(1'b1)) u_sync (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .d_i    (src_n),
    .q_o    (src_ns)
  );

  ext_irq_edge_latch u_latch (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .src_ns_i (src_ns),
    .clr_i    (clr_i),
    .mode_i   (mode),
    .fall_o   (fall),
    .latch_o  (latch_q),
    .req_o    (req_o)
  );
endmodule

// File: rtl/ext_irq_detect_chk.sv
module ext_irq_detect_chk (
  input logic clk_i,
  input logic rst_ni,
  input logic level_mode_i,
  input logic clr_i,
  input logic src_ns,
  input logic fall,
  input logic latch_q,
  input logic req_o
);
  AST_LATCH_ONLY_ON_FALL: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(latch_q) |-> $past(fall));                                  // R1
  AST_LATCH_HOLDS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    latch_q && !clr_i |=> latch_q);                                   // R2
  AST_EDGE_MODE_QUIET: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !level_mode_i && !latch_q |-> !req_o);                            // R5
  AST_LEVEL_HOLDS_REQ: assert property (@(posedge clk_i) disable iff (!rst_ni)
    level_mode_i && !src_ns |-> req_o);                               // R6
  AST_CLEAR_DROPS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    clr_i && !fall |=> !latch_q);                                     // R7
  AST_EDGE_BEATS_CLEAR: assert property (@(posedge clk_i) disable iff (!rst_ni)
    fall && clr_i |=> latch_q);                                       // R8
endmodule

bind ext_irq_detect ext_irq_detect_chk u_chk (
  .clk_i        (clk_i),
  .rst_ni       (rst_ni),
  .level_mode_i (level_mode_i),
  .clr_i        (clr_i),
  .src_ns       (src_ns),
  .fall         (fall),
  .latch_q      (latch_q),
  .req_o        (req_o)
);

// File: tb/ext_irq_detect_bench.sv
`timescale 1ns/1ps
module ext_irq_detect_bench;
  localparam int NP = 8;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          irq_n = 1'b1;
  logic [NP-1:0] port = '1;
  logic [NP-1:0] pen = '0;
  logic          lvl = 1'b0;
  logic          clr = 1'b0;
  logic          req;

  int checks = 0;
  int fails  = 0;

  always #2 clk = ~clk;

  ext_irq_detect #(.NUM_PORT(NP), .SYNC_STAGES(2)) u_ext_irq_detect (
    .clk_i(clk), .rst_ni(rst_n), .irq_ni(irq_n), .port_i(port),
    .pull_en_i(pen), .level_mode_i(lvl), .clr_i(clr), .req_o(req)
  );

  // Combined active-low source (R3, R4, R9).
  function automatic logic comb_f(logic i_n, logic [NP-1:0] p, logic [NP-1:0] e);
    logic r = i_n;
    for (int k = 0; k < NP; k++) if (e[k] && !p[k]) r = 1'b0;
    return r;
  endfunction

  // Cycle-timed model from the R1/R6 timing.
  logic m1, m2, m3, ml;
  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m1 <= 1'b1; m2 <= 1'b1; m3 <= 1'b1; ml <= 1'b0;
    end else begin
      m1 <= comb_f(irq_n, port, pen);
      m2 <= m1;
      m3 <= m2;
      ml <= (m3 & ~m2) | (ml & ~clr);
    end
  end

  function automatic logic exp_req_f(logic l, logic s2, logic md);
    return l | (md & ~s2);
  endfunction

  task automatic check(logic got, logic exp, string tag);
    checks++;
    if (got !== exp) begin
      fails++;
      $display("FAIL %s actual=%b expected=%b t=%0t", tag, got, exp, $time);
    end
  endtask

  task automatic tick(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic pulse_clr();
    clr = 1'b1; tick(1); clr = 1'b0;
  endtask

  initial begin
    #1000000;
    fails++; checks++;
    $display("FAIL watchdog R1 actual=hung expected=done");
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    tick(2);
    check(req, 1'b0, "R10 in reset");
    rst_n = 1'b1;
    tick(5);
    check(req, 1'b0, "R10 after reset");

    // R1 timing, edge mode
    irq_n = 1'b0; tick(2);
    check(req, 1'b0, "R1 not yet latched");
    tick(1);
    check(req, 1'b1, "R1 latched after third edge");
    irq_n = 1'b1; tick(5);
    check(req, 1'b1, "R2 held after release");
    pulse_clr();
    check(req, 1'b0, "R7 clear drops request");

    // R5 held low, edge mode
    irq_n = 1'b0; tick(3);
    check(req, 1'b1, "R5 setup edge");
    pulse_clr(); tick(4);
    check(req, 1'b0, "R5 held low no request");
    irq_n = 1'b1; tick(3);

    // R4 disabled port pin
    port[2] = 1'b0; tick(5);
    check(req, 1'b0, "R4 disabled pin ignored");
    port[2] = 1'b1; tick(3);

    // R3 enabled port pin
    pen[2] = 1'b1; tick(3);
    port[2] = 1'b0; tick(3);
    check(req, 1'b1, "R3 enabled pin edge");
    port[2] = 1'b1; tick(3);
    pulse_clr();
    check(req, 1'b0, "R3 cleared");

    // R9 second source while already low
    irq_n = 1'b0; tick(3);
    pulse_clr();
    check(req, 1'b0, "R9 cleared");
    port[2] = 1'b0; tick(5);
    check(req, 1'b0, "R9 no new edge");
    port[2] = 1'b1; irq_n = 1'b1; tick(4);

    // R6 edge plus level
    lvl = 1'b1;
    irq_n = 1'b0; tick(1);
    check(req, 1'b0, "R6 before sync");
    tick(1);
    check(req, 1'b1, "R6 level after two edges");
    tick(1);
    pulse_clr();
    check(req, 1'b1, "R6 level survives clear");
    irq_n = 1'b1; tick(2);
    check(req, 1'b0, "R6 drops after release");

    // R8 clear and edge on same edge
    lvl = 1'b0;
    irq_n = 1'b0; tick(2);
    clr = 1'b1; tick(1); clr = 1'b0;
    check(req, 1'b1, "R8 edge wins over clear");
    irq_n = 1'b1; tick(3);
    pulse_clr();
    check(req, 1'b0, "R8 later clear");

    // Random phase against model
    void'($urandom(32'h1234_5678));
    for (int c = 0; c < 3000; c++) begin
      check(req, exp_req_f(ml, m2, lvl), "R1 R6 random model");
      irq_n = ($urandom_range(0, 5) != 0);
      for (int k = 0; k < NP; k++) port[k] = ($urandom_range(0, 9) != 0);
      if ($urandom_range(0, 15) == 0) pen = NP'($urandom);
      if ($urandom_range(0, 63) == 0) lvl = ~lvl;
      clr = ($urandom_range(0, 3) == 0);
      tick(1);
    end
    clr = 1'b0;

    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule